// File: doc/BRIEF.md
# Banked Level Interrupt Combiner

This block collects level-sensitive interrupt sources, grouped in banks of 32, and folds them into a single request line for a parent interrupt controller. The number of banks is a parameter, either 1 or 2, so the block serves 32 or 64 sources. Each source passes through a two-flop synchroniser before the block uses it. Each bank keeps a 32-bit mask. A set mask bit blocks its source. The pending value of a bank is the synchronised source level with the masked bits removed. The parent request is high while any bank has a pending bit.

Software reaches each bank through a small register window on a plain synchronous port. The port has request, write, address and write-data signals. Reads return data one cycle later. The port is never stalled: every request is taken in the cycle it is presented, so there is no back-pressure and no ready signal. The mask can be loaded as a whole. It also has a set alias and a clear alias that change only the bits written as 1, so no read-modify-write is needed. There is no acknowledge. A source stays pending for as long as its input is high and its mask bit is clear.

Top module: `lvl_irq_bank_ctrl`

## Requirements
- R1: After reset every mask bit of every bank reads 1, `irq_o` is low, and `bus_rvalid` and `bus_rdata` are 0.
- R2: Source input `k` appears at bit `k mod 32` of the status register (window offset 0x00) of bank `k / 32`. It takes effect two rising clock edges after the input changes.
- R3: A write to the set alias (window offset 0x08) sets each mask bit whose write-data bit is 1 and leaves the other mask bits unchanged.
- R4: A write to the clear alias (window offset 0x0C) clears each mask bit whose write-data bit is 1 and leaves the other mask bits unchanged.
- R5: A write to window offset 0x04 loads the whole mask. A read of offset 0x04, 0x08 or 0x0C returns the current mask.
- R6: The pending register (window offset 0x10) reads as the synchronised status AND NOT mask. A mask bit of 1 blocks its source.
- R7: Sources are level-sensitive. A source is pending while its synchronised input is high and its mask bit is 0. It stops being pending when the input falls, and it becomes pending again when the input rises, with no acknowledge.
- R8: `irq_o` is high in exactly those cycles in which the pending value of at least one bank is non-zero. A mask change affects `irq_o` in the cycle after the write edge.
- R9: A read request returns its data with `bus_rvalid` high in the cycle after the request. `bus_rvalid` is low in every other cycle, and `bus_rdata` is 0 whenever `bus_rvalid` is low.
- R10: Writes to the status or pending offsets, to unused offsets inside a window, and to addresses above the last bank window leave all state unchanged. Reads of unused offsets and of addresses above the last window return 0.
- R11: Bank `n` occupies window offsets `n*0x20` to `n*0x20+0x1F`. An access to one bank never changes another bank's mask. Writing all ones to a bank's set alias blocks every source of that bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_BANKS*32 | Level interrupt sources, asynchronous |
| bus_req | input | 1 | Access request, taken in the same cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [4:0] select the offset, the upper bits select the bank |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data, 0 when not valid |
| irq_o | output | 1 | Combined request to the parent controller |

## Verification
A mask write and a source level can reach the pending logic at the same clock edge. A clear-alias write can land on the same edge at which the synchroniser delivers a newly raised source. The bench provokes this by raising a masked source and issuing the clear-alias write one cycle later, so that the write edge is the second synchroniser edge. It then judges the result by `irq_o` in the following cycle and by a read of the pending register, which must show the unmasked source at once. It also checks that `irq_o` stayed low one edge earlier.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int SRC_PER_BANK = 32;
  localparam int DATA_W       = 32;
  localparam int WIN_BITS     = 5;

  typedef enum logic [WIN_BITS-1:0] {
    OFS_STATUS = 5'h00,
    OFS_MASK   = 5'h04,
    OFS_SETM   = 5'h08,
    OFS_CLRM   = 5'h0C,
    OFS_PEND   = 5'h10
  } win_ofs_e;

  typedef struct packed {
    logic                req;
    logic                wr;
    logic [WIN_BITS-1:0] ofs;
    logic [DATA_W-1:0]   wdata;
  } win_acc_t;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;

endmodule

// File: rtl/irqc_addr_dec.sv
module irqc_addr_dec
  import irqc_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_BANKS-1:0] sel_o,
  output logic [WIN_BITS-1:0]  ofs_o
);

  localparam int BIDX_W = ADDR_W - WIN_BITS;

  logic [BIDX_W-1:0] bank_idx;

  assign bank_idx = addr_i[ADDR_W-1:WIN_BITS];
  assign ofs_o    = addr_i[WIN_BITS-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
    assign sel_o[b] = (bank_idx == BIDX_W'(b));
  end

endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  win_acc_t          acc_i,
  input  logic [DATA_W-1:0] status_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] pend_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] mask_nxt;
  logic              wr_hit;

  assign wr_hit = sel_i && acc_i.req && acc_i.wr;

  always_comb begin
    mask_nxt = mask_q;
    if (wr_hit) begin
      case (acc_i.ofs)
        OFS_MASK: mask_nxt = acc_i.wdata;
        OFS_SETM: mask_nxt = mask_q | acc_i.wdata;
        OFS_CLRM: mask_nxt = mask_q & ~acc_i.wdata;
        default:  mask_nxt = mask_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_nxt;
  end

  assign mask_o = mask_q;
  assign pend_o = status_i & ~mask_q;

  always_comb begin
    case (acc_i.ofs)
      OFS_STATUS:                   rdata_o = status_i;
      OFS_MASK, OFS_SETM, OFS_CLRM: rdata_o = mask_q;
      OFS_PEND:                     rdata_o = pend_o;
      default:                      rdata_o = '0;
    endcase
  end

  // R3: set alias only adds bits
  assert_set_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && acc_i.ofs == OFS_SETM) |=>
      (mask_q == ($past(mask_q) | $past(acc_i.wdata))));

  // R4: clear alias only removes bits
  assert_clr_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && acc_i.ofs == OFS_CLRM) |=>
      (mask_q == ($past(mask_q) & ~$past(acc_i.wdata))));

  // R5: direct load
  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && acc_i.ofs == OFS_MASK) |=> (mask_q == $past(acc_i.wdata)));

  // R10, R11: no mask change without a mask write to this bank
  assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_hit && (acc_i.ofs == OFS_MASK || acc_i.ofs == OFS_SETM ||
                 acc_i.ofs == OFS_CLRM)) |=> $stable(mask_q));

endmodule

// File: rtl/lvl_irq_bank_ctrl.sv
module lvl_irq_bank_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_BANKS*SRC_PER_BANK-1:0] src_i,
  input  logic                           bus_req,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic                           bus_rvalid,
  output logic [DATA_W-1:0]              bus_rdata,
  output logic                           irq_o
);

  localparam int NSRC = NUM_BANKS * SRC_PER_BANK;

  if (NUM_BANKS < 1 || NUM_BANKS > 2) begin : g_bad_banks
    $error("NUM_BANKS must be 1 or 2");
  end
  if (ADDR_W <= WIN_BITS + 1) begin : g_bad_addr
    $error("ADDR_W too small for the bank windows");
  end

  logic [NSRC-1:0]      status_all;
  logic [NUM_BANKS-1:0] bank_sel;
  logic [WIN_BITS-1:0]  ofs;
  win_acc_t             acc;
  logic [DATA_W-1:0]    bank_mask [NUM_BANKS];
  logic [DATA_W-1:0]    bank_pend [NUM_BANKS];
  logic [DATA_W-1:0]    bank_rd   [NUM_BANKS];
  logic [DATA_W-1:0]    rd_mux;
  logic                 any_pend;
  logic                 all_masked;
  logic                 rd_req;
  logic                 rvalid_q;
  logic [DATA_W-1:0]    rdata_q;

  irqc_addr_dec #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
    .addr_i (bus_addr),
    .sel_o  (bank_sel),
    .ofs_o  (ofs)
  );

  assign acc.req   = bus_req;
  assign acc.wr    = bus_wr;
  assign acc.ofs   = ofs;
  assign acc.wdata = bus_wdata;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irqc_sync #(.W(SRC_PER_BANK)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (src_i[b*SRC_PER_BANK +: SRC_PER_BANK]),
      .q_o   (status_all[b*SRC_PER_BANK +: SRC_PER_BANK])
    );

    irqc_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_i    (bank_sel[b]),
      .acc_i    (acc),
      .status_i (status_all[b*SRC_PER_BANK +: SRC_PER_BANK]),
      .mask_o   (bank_mask[b]),
      .pend_o   (bank_pend[b]),
      .rdata_o  (bank_rd[b])
    );
  end

  always_comb begin
    rd_mux     = '0;
    any_pend   = 1'b0;
    all_masked = 1'b1;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel[b]) rd_mux = rd_mux | bank_rd[b];
      any_pend   = any_pend | (|bank_pend[b]);
      all_masked = all_masked & (&bank_mask[b]);
    end
  end

  assign rd_req = bus_req && !bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_req;
      rdata_q  <= rd_req ? rd_mux : '0;
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = rdata_q;
  assign irq_o      = any_pend;

  // R9: one-cycle read latency
  assert_rd_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);

  // R9: no spurious valid, data zero when idle
  assert_rd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (!bus_rvalid && bus_rdata == '0));

  // R6, R8: fully masked banks never raise the request
  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    all_masked |-> !irq_o);

  // R8: request implies some source is synchronised high
  assert_irq_needs_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|status_all));

endmodule

// File: tb/sim_lvl_irq_bank_ctrl.sv
module sim_lvl_irq_bank_ctrl;

  localparam int NB = 2;
  localparam int AW = 8;
  localparam int NV = 26;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB*32-1:0] src = '0;
  logic          req = 1'b0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic          rvalid;
  logic [31:0]   rdata;
  logic          irq;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  lvl_irq_bank_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_req(req), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rvalid(rvalid),
    .bus_rdata(rdata), .irq_o(irq)
  );

  // entry: {op(1=read check), addr, data, expected, req number}
  typedef struct packed {
    logic        rd;
    logic [7:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0]  r;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h04, 32'h0, 32'hFFFF_FFFF, 4'd1},  // R1 mask reset
    '{1'b1, 8'h24, 32'h0, 32'hFFFF_FFFF, 4'd1},  // R1
    '{1'b1, 8'h10, 32'h0, 32'h0000_0000, 4'd1},  // R1 nothing pending
    '{1'b0, 8'h0C, 32'h0000_00FF, 32'h0, 4'd4},  // R4 clear alias
    '{1'b1, 8'h04, 32'h0, 32'hFFFF_FF00, 4'd4},
    '{1'b0, 8'h08, 32'h0000_000F, 32'h0, 4'd3},  // R3 set alias
    '{1'b1, 8'h08, 32'h0, 32'hFFFF_FF0F, 4'd3},
    '{1'b0, 8'h04, 32'h1234_5678, 32'h0, 4'd5},  // R5 direct load
    '{1'b1, 8'h0C, 32'h0, 32'h1234_5678, 4'd5},
    '{1'b1, 8'h24, 32'h0, 32'hFFFF_FFFF, 4'd11}, // R11 other bank intact
    '{1'b0, 8'h2C, 32'hFFFF_0000, 32'h0, 4'd11},
    '{1'b1, 8'h24, 32'h0, 32'h0000_FFFF, 4'd11},
    '{1'b1, 8'h04, 32'h0, 32'h1234_5678, 4'd11},
    '{1'b0, 8'h00, 32'hDEAD_BEEF, 32'h0, 4'd10}, // R10 status write
    '{1'b0, 8'h10, 32'hDEAD_BEEF, 32'h0, 4'd10}, // R10 pending write
    '{1'b0, 8'h14, 32'h0000_0000, 32'h0, 4'd10}, // R10 unused offset
    '{1'b1, 8'h04, 32'h0, 32'h1234_5678, 4'd10},
    '{1'b1, 8'h14, 32'h0, 32'h0000_0000, 4'd10},
    '{1'b0, 8'h44, 32'h0000_0000, 32'h0, 4'd10}, // R10 beyond windows
    '{1'b1, 8'h24, 32'h0, 32'h0000_FFFF, 4'd10},
    '{1'b1, 8'h44, 32'h0, 32'h0000_0000, 4'd10},
    '{1'b1, 8'h00, 32'h0, 32'h0000_0000, 4'd10},
    '{1'b0, 8'h08, 32'hFFFF_FFFF, 32'h0, 4'd11}, // R11 block all
    '{1'b0, 8'h28, 32'hFFFF_FFFF, 32'h0, 4'd11},
    '{1'b1, 8'h04, 32'h0, 32'hFFFF_FFFF, 4'd11},
    '{1'b1, 8'h24, 32'h0, 32'hFFFF_FFFF, 4'd11}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    req = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata; v = rvalid;
  endtask

  task automatic read_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    logic v;
    bus_read(a, d, v);
    chk({tag, " rvalid"}, {31'b0, v}, 32'd1);
    chk(tag, d, exp);
  endtask

  initial begin : watchdog
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic v;
    repeat (3) @(negedge clk);
    // R1 reset outputs
    chk("R1 irq after reset", {31'b0, irq}, 32'd0);
    chk("R1 rvalid after reset", {31'b0, rvalid}, 32'd0);
    chk("R1 rdata after reset", rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) begin
        bus_read(VEC[i].a, d, v);
        chk($sformatf("R%0d vec %0d rvalid", VEC[i].r, i), {31'b0, v}, 32'd1);
        chk($sformatf("R%0d vec %0d addr %h", VEC[i].r, i, VEC[i].a), d, VEC[i].e);
      end else begin
        bus_write(VEC[i].a, VEC[i].d);
      end
    end

    // R9: valid drops the cycle after a read
    @(negedge clk);
    chk("R9 rvalid idle", {31'b0, rvalid}, 32'd0);
    chk("R9 rdata idle", rdata, 32'd0);

    // R2, R6: masked sources visible in status only
    src[3] = 1'b1; src[40] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 masked no irq", {31'b0, irq}, 32'd0);
    read_chk("R2 bank0 status", 8'h00, 32'h0000_0008);
    read_chk("R2 bank1 status", 8'h20, 32'h0000_0100);
    read_chk("R6 bank0 pend masked", 8'h10, 32'h0);

    // R8: unmask raises the request
    bus_write(8'h0C, 32'h0000_0008);
    chk("R8 irq after unmask", {31'b0, irq}, 32'd1);
    read_chk("R6 bank0 pend", 8'h10, 32'h0000_0008);

    // R2, R7: two-edge delay, level follows input
    src[3] = 1'b0;
    @(negedge clk);
    chk("R2 irq one edge after fall", {31'b0, irq}, 32'd1);
    @(negedge clk);
    chk("R7 irq after fall", {31'b0, irq}, 32'd0);
    src[3] = 1'b1;
    @(negedge clk);
    chk("R2 irq one edge after rise", {31'b0, irq}, 32'd0);
    @(negedge clk);
    chk("R7 irq re-pends", {31'b0, irq}, 32'd1);

    // R11: bank1 window
    bus_write(8'h2C, 32'h0000_0100);
    read_chk("R6 bank1 pend", 8'h30, 32'h0000_0100);
    bus_write(8'h28, 32'hFFFF_FFFF);
    read_chk("R11 bank1 blocked", 8'h30, 32'h0);
    chk("R8 irq from bank0 only", {31'b0, irq}, 32'd1);
    bus_write(8'h08, 32'h0000_0008);
    chk("R8 irq all masked", {31'b0, irq}, 32'd0);

    // R8, R6: clear-alias write on the same edge the source arrives
    src[5] = 1'b1;
    @(negedge clk);
    chk("R8 before coincident edge", {31'b0, irq}, 32'd0);
    req = 1'b1; wr = 1'b1; addr = 8'h0C; wdata = 32'h0000_0020;
    @(negedge clk);
    req = 1'b0; wr = 1'b0;
    chk("R8 coincident unmask and arrival", {31'b0, irq}, 32'd1);
    read_chk("R6 coincident pend", 8'h10, 32'h0000_0020);
    read_chk("R4 coincident mask", 8'h04, 32'hFFFF_FFDF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule